// File: doc/BRIEF.md
# Processor Status Register with Flag Write Masking

This block holds the 8-bit status word of a small 8-bit CPU core: the ALU carry, half-byte carry and zero flags, two reset-cause flags (power-down and watchdog time-out), and three bank-select bits. Software can write it over the data bus like any other register. The ALU can update the arithmetic flags in the same cycle through a separate port that has one update enable per flag. Four event inputs keep the reset-cause flags current: power-up, watchdog clear, sleep and watchdog time-out.

When an instruction writes the register and also produces flags, the ALU values win for each flag it updates. A clear-register operation aimed at this register gets special treatment: it zeroes the three bank-select bits, sets zero, and leaves the other bits alone. The two reset-cause flags cannot be written from the bus at all. Alongside the register value, the block outputs the base address of the directly addressed bank, decoded from the two direct bank bits.

Bit layout, from bit 7 down to bit 0: indirect bank select, direct bank bit 1, direct bank bit 0, time-out, power-down, zero, digit carry, carry.

Top module: `status_reg`

## Requirements
- R1: While rst_n is low at a clock edge, the register loads 0x18: time-out (bit 4) and power-down (bit 3) are 1 and every other bit is 0. The bank base then reads 0.
- R2: A bus write (wr_en_i) loads bits 7:5 and 2:0 from wr_data_i. Bits 4:3 keep their value whatever the written data.
- R3: For each flag whose update enable is set (alu_upd_i bit 0 = carry, bit 1 = digit carry, bit 2 = zero), the flag takes the matching alu_flags_i bit. This holds even when a bus write or a clear happens in the same cycle. A flag whose enable is clear follows the bus write.
- R4: A clear (clr_i) sets bits 7:5 to 0 and zero to 1, and leaves carry, digit carry, time-out and power-down unchanged. A bus write in the same cycle is ignored.
- R5: Power-up (pwr_up_i) sets both time-out and power-down. It takes priority over every other event.
- R6: A watchdog clear (wdt_clr_i) sets both time-out and power-down.
- R7: Sleep (sleep_i) sets time-out and clears power-down. It takes priority over a watchdog clear.
- R8: A watchdog time-out (wdt_to_i) clears time-out and leaves power-down unchanged. For time-out, it takes priority over sleep and watchdog clear.
- R9: bank_base_o equals {bit 6, bit 5} times BANK_BYTES (0, 128, 256 or 384 by default). The indirect bank bit (bit 7) has no effect on it.
- R10: In a cycle with no write, clear, ALU update or event, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Bus write to this register |
| wr_data_i | input | 8 | Bus write data |
| clr_i | input | 1 | Clear-register operation aimed at this register |
| alu_upd_i | input | 3 | Per-flag update enables {zero, digit carry, carry} |
| alu_flags_i | input | 3 | ALU flag values {zero, digit carry, carry} |
| pwr_up_i | input | 1 | Power-up event |
| wdt_clr_i | input | 1 | Watchdog-clear instruction |
| sleep_i | input | 1 | Sleep instruction |
| wdt_to_i | input | 1 | Watchdog time-out event |
| status_o | output | 8 | Register value |
| bank_base_o | output | 9 | Base address of the directly addressed bank |

## Verification
The bench uses the default BANK_BYTES of 128, so the bank base output is 9 bits wide. The bench visits all four bank bases, 0, 128, 256 and 384, and also writes the indirect bit to show it does not move the base. At this size, each priority pairing can be reached in one cycle: ALU against bus, clear against bus, ALU against clear, time-out against sleep, and power-up against time-out.

// File: rtl/status_pkg.sv
// Shared bit positions and widths for the status register.
// Assumes an 8-bit status word with the layout given in the brief.
package status_pkg;
    localparam int unsigned WORD_W   = 8;
    localparam int unsigned NFLAGS   = 3;
    localparam int unsigned BIT_C    = 0;
    localparam int unsigned BIT_DC   = 1;
    localparam int unsigned BIT_Z    = 2;
    localparam int unsigned BIT_PD   = 3;
    localparam int unsigned BIT_TO   = 4;
    localparam int unsigned BIT_RP0  = 5;
    localparam int unsigned BIT_RP1  = 6;
    localparam int unsigned BIT_IRP  = 7;
endpackage

// File: rtl/status_alu_flags.sv
// Carry, digit-carry and zero flags.
// Priority for each flag: ALU update, then clear, then bus write.
// On a clear, zero is set and the two carries hold.
module status_alu_flags
    import status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [NFLAGS-1:0] wr_bits_i,
    input  logic              clr_i,
    input  logic [NFLAGS-1:0] upd_i,
    input  logic [NFLAGS-1:0] alu_i,
    output logic [NFLAGS-1:0] flags_o
);
    logic [NFLAGS-1:0] flags_q;
    logic [NFLAGS-1:0] flags_d;

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        // Next-value selection for flag i, following the priority order.
        always_comb begin
            if (upd_i[i])
                flags_d[i] = alu_i[i];
            else if (clr_i)
                flags_d[i] = (i == BIT_Z) ? 1'b1 : flags_q[i];
            else if (wr_en_i)
                flags_d[i] = wr_bits_i[i];
            else
                flags_d[i] = flags_q[i];
        end

        // R3
        alu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && upd_i[i]) |=> (flags_o[i] == $past(alu_i[i])));
    end

    // Flag storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R4
    clr_sets_z_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_i && !upd_i[BIT_Z]) |=> flags_o[BIT_Z]);
endmodule

// File: rtl/status_reset_flags.sv
// Time-out and power-down flags, driven only by events.
// The bus cannot write them. Priority: power-up first; for time-out,
// then watchdog time-out, sleep, watchdog clear; for power-down,
// then sleep, watchdog clear.
module status_reset_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up_i,
    input  logic wdt_clr_i,
    input  logic sleep_i,
    input  logic wdt_to_i,
    output logic to_o,
    output logic pd_o
);
    logic to_q, pd_q, to_d, pd_d;

    // Event-driven next value for the time-out flag.
    always_comb begin
        if (pwr_up_i)       to_d = 1'b1;
        else if (wdt_to_i)  to_d = 1'b0;
        else if (sleep_i)   to_d = 1'b1;
        else if (wdt_clr_i) to_d = 1'b1;
        else                to_d = to_q;
    end

    // Event-driven next value for the power-down flag.
    always_comb begin
        if (pwr_up_i)       pd_d = 1'b1;
        else if (sleep_i)   pd_d = 1'b0;
        else if (wdt_clr_i) pd_d = 1'b1;
        else                pd_d = pd_q;
    end

    // Flag storage; both flags come up set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_q <= 1'b1;
            pd_q <= 1'b1;
        end else begin
            to_q <= to_d;
            pd_q <= pd_d;
        end
    end

    assign to_o = to_q;
    assign pd_o = pd_q;

    // R10
    no_event_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !pwr_up_i && !wdt_clr_i && !sleep_i && !wdt_to_i)
        |=> ($stable(to_o) && $stable(pd_o)));
    // R8
    timeout_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wdt_to_i && !pwr_up_i) |=> (!to_o && $stable(pd_o)));
    // R7
    sleep_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && sleep_i && !pwr_up_i) |=> !pd_o);
endmodule

// File: rtl/status_bank_sel.sv
// Three bank-select bits and the decode of the direct bank base address.
// A clear zeroes the bits and wins over a bus write. The indirect bit
// plays no part in the decode.
module status_bank_sel #(
    parameter int unsigned BANK_BYTES = 128,
    localparam int unsigned BASE_W    = $clog2(BANK_BYTES) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_bits_i,
    input  logic              clr_i,
    output logic [2:0]        sel_o,
    output logic [BASE_W-1:0] base_o
);
    localparam int unsigned OFS_W = BASE_W - 2;

    logic [2:0] sel_q;

    // Bank-select storage: clear first, then bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (clr_i)   sel_q <= '0;
        else if (wr_en_i) sel_q <= wr_bits_i;
    end

    assign sel_o  = sel_q;
    // Base address: the two direct bits above a zero in-bank offset.
    assign base_o = {sel_q[1:0], {OFS_W{1'b0}}};

    // R2
    bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en_i && !clr_i) |=> (sel_o == $past(wr_bits_i)));
    // R4
    clr_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && clr_i) |=> (sel_o == 3'b000));
endmodule

// File: rtl/status_reg.sv
// Top of the status register. Puts the word together from the flag,
// reset-cause and bank units, and exposes the decoded bank base.
// Assumes at most one instruction per cycle drives the write, clear and ALU ports.
module status_reg
    import status_pkg::*;
#(
    parameter int unsigned BANK_BYTES = 128,
    localparam int unsigned BASE_W    = $clog2(BANK_BYTES) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              clr_i,
    input  logic [NFLAGS-1:0] alu_upd_i,
    input  logic [NFLAGS-1:0] alu_flags_i,
    input  logic              pwr_up_i,
    input  logic              wdt_clr_i,
    input  logic              sleep_i,
    input  logic              wdt_to_i,
    output logic [WORD_W-1:0] status_o,
    output logic [BASE_W-1:0] bank_base_o
);
    logic [NFLAGS-1:0] flags;
    logic              to_bit, pd_bit;
    logic [2:0]        sel;

    status_alu_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_bits_i (wr_data_i[BIT_Z:BIT_C]),
        .clr_i     (clr_i),
        .upd_i     (alu_upd_i),
        .alu_i     (alu_flags_i),
        .flags_o   (flags)
    );

    status_reset_flags u_rst (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_up_i  (pwr_up_i),
        .wdt_clr_i (wdt_clr_i),
        .sleep_i   (sleep_i),
        .wdt_to_i  (wdt_to_i),
        .to_o      (to_bit),
        .pd_o      (pd_bit)
    );

    status_bank_sel #(.BANK_BYTES(BANK_BYTES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_bits_i (wr_data_i[BIT_IRP:BIT_RP0]),
        .clr_i     (clr_i),
        .sel_o     (sel),
        .base_o    (bank_base_o)
    );

    assign status_o = {sel, to_bit, pd_bit, flags};

    // R2
    ro_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en_i && !pwr_up_i && !wdt_clr_i && !sleep_i && !wdt_to_i)
        |=> $stable(status_o[BIT_TO:BIT_PD]));
    // R1
    reset_val_chk: assert property (@(posedge clk)
        !rst_n |=> (status_o == 8'h18));
endmodule

// File: tb/sim_status_reg.sv
module sim_status_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, clr, pwr_up, wdt_clr, sleep_ev, wdt_to;
    logic [7:0] wr_data;
    logic [2:0] upd, aluf;
    logic [7:0] status;
    logic [8:0] base;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_reg u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .clr_i(clr), .alu_upd_i(upd), .alu_flags_i(aluf),
        .pwr_up_i(pwr_up), .wdt_clr_i(wdt_clr), .sleep_i(sleep_ev),
        .wdt_to_i(wdt_to), .status_o(status), .bank_base_o(base)
    );

    task automatic idle_inputs();
        wr_en = 0; wr_data = 0; clr = 0; upd = 0; aluf = 0;
        pwr_up = 0; wdt_clr = 0; sleep_ev = 0; wdt_to = 0;
    endtask

    // Let one clock edge pass with the current inputs, then sample at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic chk_status(string req, logic [7:0] exp);
        n_tests++;
        if (status !== exp) begin
            n_fail++;
            $display("FAIL %s status actual=%h expected=%h", req, status, exp);
        end
    endtask

    task automatic chk_base(string req, logic [8:0] exp);
        n_tests++;
        if (base !== exp) begin
            n_fail++;
            $display("FAIL %s bank_base actual=%0d expected=%0d", req, base, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] d);
        wr_en = 1; wr_data = d; step();
    endtask

    task automatic t_reset();
        rst_n = 0; idle_inputs();
        step(); step();
        chk_status("R1", 8'h18);
        chk_base("R1", 9'd0);
        rst_n = 1;
    endtask

    task automatic t_bus_bank();
        bus_write(8'hFF); chk_status("R2", 8'hFF); chk_base("R9", 9'd384);
        bus_write(8'h00); chk_status("R2", 8'h18); chk_base("R9", 9'd0);
        bus_write(8'hA5); chk_status("R2", 8'hBD); chk_base("R9", 9'd128);
        bus_write(8'hC0); chk_base("R9", 9'd256);
        bus_write(8'h80); chk_status("R9", 8'h98); chk_base("R9", 9'd0);
    endtask

    task automatic t_alu_priority();
        wr_en = 1; wr_data = 8'h07; upd = 3'b101; aluf = 3'b000; step();
        chk_status("R3", 8'h1A);
        upd = 3'b010; aluf = 3'b000; step();
        chk_status("R3", 8'h18);
        upd = 3'b001; aluf = 3'b001; step();
        chk_status("R3", 8'h19);
    endtask

    task automatic t_clear();
        bus_write(8'hE3); chk_status("R2", 8'hFB);
        clr = 1; wr_en = 1; wr_data = 8'h00; step();
        chk_status("R4", 8'h1F); chk_base("R4", 9'd0);
        clr = 1; upd = 3'b100; aluf = 3'b000; step();
        chk_status("R3", 8'h1B);
    endtask

    task automatic t_events();
        sleep_ev = 1; step(); chk_status("R7", 8'h13);
        wdt_to = 1; step(); chk_status("R8", 8'h03);
        wdt_clr = 1; step(); chk_status("R6", 8'h1B);
        sleep_ev = 1; wdt_clr = 1; step(); chk_status("R7", 8'h13);
        sleep_ev = 1; wdt_to = 1; step(); chk_status("R8", 8'h03);
        pwr_up = 1; wdt_to = 1; sleep_ev = 1; step(); chk_status("R5", 8'h1B);
        wdt_to = 1; wr_en = 1; wr_data = 8'h18; step(); chk_status("R2", 8'h08);
    endtask

    task automatic t_hold();
        repeat (3) step();
        chk_status("R10", 8'h08);
        chk_base("R10", 9'd0);
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        @(negedge clk);
        t_reset();
        t_bus_bank();
        t_alu_priority();
        t_clear();
        t_events();
        t_hold();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule